// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Unit

This block sits beside the ALU in the execute stage of a five-stage, 32-bit load/store pipeline. It takes the two source register numbers of the instruction now in execute and compares each against the destination numbers held in the two later pipeline registers: execute/memory (the newer result) and memory/writeback (the older one). For each ALU operand it produces a two-bit select code that names where the operand comes from. It also contains the two multiplexers that use those codes to pick between the register-file read value and the two in-flight results.

Because a result is ready at the end of execute and a consumer needs it at the start of execute, this bypass lets dependent ALU instructions issue back to back with no bubble. The unit is purely combinational and holds no state. It has no state machine: its "states" are the three select codes, and a "transition" is simply the outputs following the inputs in the same cycle. Stall detection for loads, the register file, the pipeline registers and the ALU are all outside the block.

Top module: `opnd_bypass`

## Requirements
- R1: `sel_a` is 2'b10 when `exm_wr_en` is 1, `exm_dst` is nonzero and `exm_dst` equals `src_a_idx`.
- R2: `sel_b` is 2'b10 under the same execute/memory test as R1, compared against `src_b_idx`.
- R3: When the execute/memory test fails for an operand and `mwb_wr_en` is 1, `mwb_dst` is nonzero and `mwb_dst` equals that operand's source number, its select is 2'b01.
- R4: When both the execute/memory and memory/writeback tests match the same source, the select is 2'b10 and the newer execute/memory value is used.
- R5: A stage whose destination number is 0 never causes a bypass, even when its write flag is set and the source is also 0.
- R6: A stage whose write flag is 0 never causes a bypass, whatever its destination number.
- R7: When no test matches, the select is 2'b00 and the operand equals the register-file read value.
- R8: Each operand output equals `rf_*_data` for code 2'b00, `mwb_data` for 2'b01 and `exm_data` for 2'b10, in the same cycle as the inputs. Code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | First source register number of the execute-stage instruction |
| src_b_idx | input | 5 | Second source register number of the execute-stage instruction |
| exm_wr_en | input | 1 | Execute/memory instruction writes a register |
| exm_dst | input | 5 | Execute/memory destination register number |
| exm_data | input | 32 | Execute/memory result value |
| mwb_wr_en | input | 1 | Memory/writeback instruction writes a register |
| mwb_dst | input | 5 | Memory/writeback destination register number |
| mwb_data | input | 32 | Memory/writeback result value |
| rf_a_data | input | 32 | Register-file read value for the first operand |
| rf_b_data | input | 32 | Register-file read value for the second operand |
| sel_a | output | 2 | Source select code for the first operand |
| sel_b | output | 2 | Source select code for the second operand |
| opnd_a | output | 32 | First ALU operand after bypass |
| opnd_b | output | 32 | Second ALU operand after bypass |

## Verification
The hardest situation to reach is a double match: both later stages must write the same nonzero register that the execute instruction reads. In a real pipeline, that takes two back-to-back writes to one register followed by a read. The stimulus forces it directly at the ports by giving both stages the same destination, with distinct data on each, so a wrong priority shows up in the operand value. Register 0 is driven on the sources and on both destinations with the write flags set, to show that the zero guard overrides an exact match.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } byp_sel_e;

endpackage

// File: rtl/byp_match.sv
// One comparator: does a later stage hold a usable result for this source?
module byp_match #(
    parameter int REG_W = 5
) (
    input  logic             wr_en,
    input  logic [REG_W-1:0] dst_idx,
    input  logic [REG_W-1:0] src_idx,
    output logic             hit
);

    localparam logic [REG_W-1:0] ZERO_REG = '0;

    always_comb begin
        hit = wr_en && (dst_idx != ZERO_REG) && (dst_idx == src_idx);
    end

endmodule

// File: rtl/byp_select.sv
// Priority pick: the newer stage wins over the older one.
module byp_select
    import bypass_pkg::*;
(
    input  logic     hit_new,
    input  logic     hit_old,
    output byp_sel_e sel
);

    always_comb begin
        unique case ({hit_new, hit_old})
            2'b10, 2'b11: sel = SEL_MEM;
            2'b01:        sel = SEL_WB;
            default:      sel = SEL_RF;
        endcase
    end

endmodule

// File: rtl/byp_mux.sv
module byp_mux
    import bypass_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  byp_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] opnd
);

    always_comb begin
        unique case (sel)
            SEL_MEM: opnd = mem_val;
            SEL_WB:  opnd = wb_val;
            default: opnd = rf_val;
        endcase
    end

endmodule

// File: rtl/opnd_bypass.sv
module opnd_bypass
    import bypass_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_W-1:0]  src_a_idx,
    input  logic [REG_W-1:0]  src_b_idx,
    input  logic              exm_wr_en,
    input  logic [REG_W-1:0]  exm_dst,
    input  logic [DATA_W-1:0] exm_data,
    input  logic              mwb_wr_en,
    input  logic [REG_W-1:0]  mwb_dst,
    input  logic [DATA_W-1:0] mwb_data,
    input  logic [DATA_W-1:0] rf_a_data,
    input  logic [DATA_W-1:0] rf_b_data,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);

    localparam int N_OPND = 2;

    logic [N_OPND-1:0][REG_W-1:0]  src_vec;
    logic [N_OPND-1:0][DATA_W-1:0] rf_vec;
    logic [N_OPND-1:0][DATA_W-1:0] out_vec;
    byp_sel_e                      sel_vec [N_OPND];

    assign src_vec = {src_b_idx, src_a_idx};
    assign rf_vec  = {rf_b_data, rf_a_data};

    for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
        logic hit_mem;
        logic hit_wb;

        byp_match #(.REG_W(REG_W)) u_mem_cmp (
            .wr_en   (exm_wr_en),
            .dst_idx (exm_dst),
            .src_idx (src_vec[k]),
            .hit     (hit_mem)
        );

        byp_match #(.REG_W(REG_W)) u_wb_cmp (
            .wr_en   (mwb_wr_en),
            .dst_idx (mwb_dst),
            .src_idx (src_vec[k]),
            .hit     (hit_wb)
        );

        byp_select u_pick (
            .hit_new (hit_mem),
            .hit_old (hit_wb),
            .sel     (sel_vec[k])
        );

        byp_mux #(.DATA_W(DATA_W)) u_mux (
            .sel     (sel_vec[k]),
            .rf_val  (rf_vec[k]),
            .mem_val (exm_data),
            .wb_val  (mwb_data),
            .opnd    (out_vec[k])
        );

        // Checks on the select against the stage inputs, across the modules
        always_comb begin
            if (!$isunknown({src_vec[k], exm_wr_en, exm_dst, mwb_wr_en, mwb_dst})) begin
                p_legal_code_r8: assert (sel_vec[k] != 2'b11);
                if (sel_vec[k] == SEL_MEM) begin
                    p_mem_needs_wr_r6:   assert (exm_wr_en);
                    p_mem_nonzero_r5:    assert (exm_dst != '0);
                    p_mem_same_reg_r1:   assert (exm_dst == src_vec[k]);
                end
                if (sel_vec[k] == SEL_WB) begin
                    p_wb_nonzero_r5:     assert (mwb_wr_en && mwb_dst != '0);
                    p_wb_not_newer_r4:   assert (!(exm_wr_en && exm_dst != '0
                                                   && exm_dst == src_vec[k]));
                end
                if (sel_vec[k] == SEL_RF && !$isunknown(rf_vec[k])) begin
                    p_rf_passthru_r7:    assert (out_vec[k] == rf_vec[k]);
                end
            end
        end
    end

    assign sel_a  = sel_vec[0];
    assign sel_b  = sel_vec[1];
    assign opnd_a = out_vec[0];
    assign opnd_b = out_vec[1];

endmodule

// File: tb/opnd_bypass_tb_top.sv
module opnd_bypass_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 11;

    typedef struct packed {
        logic [4:0] sa;
        logic [4:0] sb;
        logic       ew;
        logic [4:0] ed;
        logic       ww;
        logic [4:0] wd;
        logic [1:0] xa;
        logic [1:0] xb;
    } vec_t;

    // sa, sb, exm_wr, exm_dst, mwb_wr, mwb_dst, exp sel_a, exp sel_b
    localparam vec_t VECS [N_VEC] = '{
        '{5'd3,  5'd4,  1'b1, 5'd3,  1'b0, 5'd0,  2'b10, 2'b00}, // R1 back-to-back
        '{5'd7,  5'd9,  1'b1, 5'd9,  1'b0, 5'd0,  2'b00, 2'b10}, // R2
        '{5'd5,  5'd6,  1'b1, 5'd1,  1'b1, 5'd5,  2'b01, 2'b00}, // R3 two apart
        '{5'd6,  5'd5,  1'b0, 5'd0,  1'b1, 5'd5,  2'b00, 2'b01}, // R3 on B
        '{5'd8,  5'd8,  1'b1, 5'd8,  1'b1, 5'd8,  2'b10, 2'b10}, // R4 double match
        '{5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00}, // R5 register zero
        '{5'd12, 5'd12, 1'b0, 5'd12, 1'b1, 5'd12, 2'b01, 2'b01}, // R6 newer not writing
        '{5'd12, 5'd3,  1'b0, 5'd12, 1'b0, 5'd3,  2'b00, 2'b00}, // R6 neither writing
        '{5'd31, 5'd31, 1'b1, 5'd31, 1'b0, 5'd31, 2'b10, 2'b10}, // R1 R2 top register
        '{5'd2,  5'd2,  1'b1, 5'd3,  1'b1, 5'd4,  2'b00, 2'b00}, // R7 no match
        '{5'd4,  5'd10, 1'b1, 5'd10, 1'b1, 5'd4,  2'b01, 2'b10}  // R3 R2 mixed
    };

    logic        clk = 1'b0;
    logic [4:0]  src_a_idx, src_b_idx, exm_dst, mwb_dst;
    logic        exm_wr_en, mwb_wr_en;
    logic [31:0] exm_data, mwb_data, rf_a_data, rf_b_data;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opnd_a, opnd_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opnd_bypass dut_i (
        .src_a_idx (src_a_idx),
        .src_b_idx (src_b_idx),
        .exm_wr_en (exm_wr_en),
        .exm_dst   (exm_dst),
        .exm_data  (exm_data),
        .mwb_wr_en (mwb_wr_en),
        .mwb_dst   (mwb_dst),
        .mwb_data  (mwb_data),
        .rf_a_data (rf_a_data),
        .rf_b_data (rf_b_data),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b)
    );

    function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] rf);
        if (s == 2'b10) return exm_data;
        if (s == 2'b01) return mwb_data;
        return rf;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v, input logic [31:0] ed, input logic [31:0] wd,
                         input logic [31:0] ra, input logic [31:0] rb);
        @(posedge clk);
        src_a_idx = v.sa; src_b_idx = v.sb;
        exm_wr_en = v.ew; exm_dst   = v.ed;
        mwb_wr_en = v.ww; mwb_dst   = v.wd;
        exm_data  = ed;   mwb_data  = wd;
        rf_a_data = ra;   rf_b_data = rb;
        @(negedge clk);
    endtask

    task automatic check_vec(input string req, input vec_t v);
        chk({req, " sel_a"},  {30'd0, sel_a}, {30'd0, v.xa});
        chk({req, " sel_b"},  {30'd0, sel_b}, {30'd0, v.xb});
        chk({req, " opnd_a R8"}, opnd_a, pick(v.xa, rf_a_data));
        chk({req, " opnd_b R8"}, opnd_b, pick(v.xb, rf_b_data));
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        vec_t v;
        // Idle state with all inputs zero: R7 register-file path
        v = '{5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 2'b00, 2'b00};
        apply(v, 32'h0, 32'h0, 32'h0, 32'h0);
        check_vec("R7 idle", v);

        for (int i = 0; i < N_VEC; i++) begin
            apply(VECS[i], 32'hE0E0_1000 + i, 32'hB0B0_2000 + i,
                  32'hAAAA_0000 + i, 32'hBBBB_0000 + i);
            check_vec($sformatf("vec%0d", i), VECS[i]);
        end

        // R4 with different data: the newer value must appear on both operands
        v = '{5'd17, 5'd17, 1'b1, 5'd17, 1'b1, 5'd17, 2'b10, 2'b10};
        apply(v, 32'h1234_5678, 32'h8765_4321, 32'h0, 32'hFFFF_FFFF);
        chk("R4 newer value a", opnd_a, 32'h1234_5678);
        chk("R4 newer value b", opnd_b, 32'h1234_5678);

        // R5: older stage writes register 0 with nonzero data, sources read 0
        v = '{5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd0, 2'b00, 2'b00};
        apply(v, 32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h0, 32'h0);
        chk("R5 zero reg a", opnd_a, 32'h0);
        chk("R5 zero reg b", opnd_b, 32'h0);

        // R6: newer stage matches but does not write; older misses
        v = '{5'd20, 5'd21, 1'b0, 5'd20, 1'b1, 5'd22, 2'b00, 2'b00};
        apply(v, 32'h5555_5555, 32'h6666_6666, 32'h0101_0101, 32'h0202_0202);
        check_vec("R6 no write", v);

        // R8: same cycle response when only data changes
        v = '{5'd9, 5'd1, 1'b1, 5'd9, 1'b1, 5'd1, 2'b10, 2'b01};
        apply(v, 32'h0000_0009, 32'h0000_0001, 32'h0, 32'h0);
        apply(v, 32'h9999_0000, 32'h1111_0000, 32'h0, 32'h0);
        chk("R8 follows exm data", opnd_a, 32'h9999_0000);
        chk("R8 follows mwb data", opnd_b, 32'h1111_0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule